// File: doc/BRIEF.md
# AUX Request Byte Composer

This block turns one DisplayPort AUX request into the byte sequence that a line engine sends. On a start strobe it captures a 4-bit command, a 20-bit address, a payload length of 0 to 16, up to 16 payload bytes, an I2C-or-native selector and a start delay. It then writes the request bytes into a transmit buffer, one byte per clock, starting at index 0. After the last byte it acknowledges the engine's previous completion flag and waits until the engine's done status reads low. Only then does it pulse the launch output.

The header is packed tightly. The command and the upper address nibble share the first byte. A length byte is present only when the length is nonzero. Payload bytes follow only for write commands. The total byte count and the delay are presented to the line engine for the whole request.

Top module: `aux_req_composer`

## Requirements
- R1: Buffer byte 0 is the command in bits 7:4 and address bits 19:16 in bits 3:0.
- R2: Buffer byte 1 is address bits 15:8 and buffer byte 2 is address bits 7:0.
- R3: When the length is nonzero, buffer byte 3 holds the length minus one; a zero-length request writes no length byte.
- R4: The byte count output is 3 for a zero-length request and 4 otherwise, plus the length for write requests only.
- R5: A request is a write when i2c_i=0 and cmd_i=4'b1000, or when i2c_i=1 and cmd_i is 4'b0000 or 4'b0100. Every other request writes no payload bytes.
- R6: Buffer writes start at index 0 in the cycle after the start strobe. They advance by one index per clock with no gaps, and payload byte k (payload_i[8k+7:8k]) goes to index 4+k.
- R7: In the cycle after the last buffer write, done_ack_o pulses for one cycle. go_o pulses for one cycle only once done_st_i has been sampled low after that acknowledge, and no earlier than two cycles after it.
- R8: busy_o rises the cycle after an accepted start strobe and falls the cycle after go_o. Start strobes while busy_o is high are ignored.
- R9: After reset, busy_o, buf_we_o, done_ack_o and go_o are low and the byte count is 0.
- R10: delay_o holds the start delay captured with the accepted start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| go_i | input | 1 | Start strobe for a new request |
| i2c_i | input | 1 | 1 = I2C-over-AUX command, 0 = native command |
| cmd_i | input | 4 | Request command |
| addr_i | input | 20 | Request address |
| len_i | input | 5 | Payload length, 0 to 16 |
| payload_i | input | 128 | Payload bytes, byte k at bits 8k+7:8k |
| delay_i | input | 4 | Start delay for the line engine |
| done_st_i | input | 1 | Line engine done status |
| busy_o | output | 1 | Request in progress |
| buf_we_o | output | 1 | Transmit buffer write enable |
| buf_idx_o | output | 5 | Transmit buffer write index |
| buf_data_o | output | 8 | Transmit buffer write data |
| wr_cnt_o | output | 5 | Number of bytes to transmit |
| delay_o | output | 4 | Captured start delay |
| done_ack_o | output | 1 | Acknowledge of the previous completion flag |
| go_o | output | 1 | Launch pulse to the line engine |

## Verification
The start strobe is taken at clock edge 0. From then on, buffer byte k is visible after edge k, and count and delay are visible after edge 0. For a request of n bytes, the acknowledge is visible after edge n and the launch pulse after edge n+2. If done_st_i is released later, the launch follows the edge after the release. The bench samples every output on the falling edge after each rising edge and tracks the rising-edge number. Each write, acknowledge, launch and busy drop is compared with the cycle predicted from n and the release cycle, as well as with its value.

// File: rtl/aux_req_pkg.sv
package aux_req_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EMIT,
    ST_ACK,
    ST_WAIT,
    ST_LAUNCH
  } seq_st_e;
endpackage

// File: rtl/aux_req_hdr.sv
module aux_req_hdr #(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int CNT_W   = $clog2(MAX_LEN + 5)
) (
  input  logic             i2c_i,
  input  logic [3:0]       cmd_i,
  input  logic [19:0]      addr_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [3:0][7:0]  hdr_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic is_wr;
  logic has_len;

  // write decode differs between native and I2C command spaces
  always_comb begin
    if (i2c_i) is_wr = (cmd_i == 4'b0000) || (cmd_i == 4'b0100);
    else       is_wr = (cmd_i == 4'b1000);
  end

  assign has_len = (len_i != '0);

  assign hdr_o[0] = {cmd_i, addr_i[19:16]};
  assign hdr_o[1] = addr_i[15:8];
  assign hdr_o[2] = addr_i[7:0];
  assign hdr_o[3] = 8'(len_i - LEN_W'(1));

  assign cnt_o = (has_len ? CNT_W'(4) : CNT_W'(3)) + (is_wr ? CNT_W'(len_i) : '0);
endmodule

// File: rtl/aux_req_bytesel.sv
module aux_req_bytesel #(
  parameter int MAX_LEN = 16,
  parameter int IDX_W   = $clog2(MAX_LEN + 5)
) (
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [3:0][7:0]          hdr_i,
  input  logic [MAX_LEN-1:0][7:0]  pay_i,
  output logic [7:0]               data_o
);
  always_comb begin
    data_o = '0;
    if (idx_i < IDX_W'(4)) begin
      data_o = hdr_i[idx_i[1:0]];
    end else begin
      for (int k = 0; k < MAX_LEN; k++)
        if (idx_i == IDX_W'(k + 4)) data_o = pay_i[k];
    end
  end
endmodule

// File: rtl/aux_req_seq.sv
module aux_req_seq
  import aux_req_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             done_st_i,
  input  logic [IDX_W-1:0] cnt_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             load_o,
  output logic             busy_o,
  output logic             we_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] cnt_o,
  output logic [DLY_W-1:0] dly_o,
  output logic             ack_o,
  output logic             go_o
);
  seq_st_e st_q;
  logic [IDX_W-1:0] idx_q, cnt_q;
  logic [DLY_W-1:0] dly_q;

  assign load_o = (st_q == ST_IDLE) && go_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
      dly_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go_i) begin
          st_q  <= ST_EMIT;
          idx_q <= '0;
          cnt_q <= cnt_i;
          dly_q <= dly_i;
        end
        ST_EMIT: begin
          if (idx_q == cnt_q - IDX_W'(1)) st_q <= ST_ACK;
          else                            idx_q <= idx_q + IDX_W'(1);
        end
        ST_ACK:    st_q <= ST_WAIT;
        ST_WAIT:   if (!done_st_i) st_q <= ST_LAUNCH;
        ST_LAUNCH: st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign we_o   = (st_q == ST_EMIT);
  assign ack_o  = (st_q == ST_ACK);
  assign go_o   = (st_q == ST_LAUNCH);
  assign idx_o  = idx_q;
  assign cnt_o  = cnt_q;
  assign dly_o  = dly_q;

  assert_first_idx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_o) |-> idx_o == '0);
  assert_idx_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o && $past(we_o) |-> idx_o == $past(idx_o) + IDX_W'(1));
  assert_ack_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_o) |-> ack_o);
  assert_go_after_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> !$past(done_st_i) && !$past(ack_o));
  assert_go_ends_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |=> !go_o && !busy_o);
  assert_ignore_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && go_i |=> $stable(cnt_o) && $stable(dly_o));
endmodule

// File: rtl/aux_req_composer.sv
module aux_req_composer #(
  parameter int MAX_LEN = 16,
  parameter int DLY_W   = 4,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int IDX_W  = $clog2(MAX_LEN + 5)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 go_i,
  input  logic                 i2c_i,
  input  logic [3:0]           cmd_i,
  input  logic [19:0]          addr_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic [MAX_LEN*8-1:0] payload_i,
  input  logic [DLY_W-1:0]     delay_i,
  input  logic                 done_st_i,
  output logic                 busy_o,
  output logic                 buf_we_o,
  output logic [IDX_W-1:0]     buf_idx_o,
  output logic [7:0]           buf_data_o,
  output logic [IDX_W-1:0]     wr_cnt_o,
  output logic [DLY_W-1:0]     delay_o,
  output logic                 done_ack_o,
  output logic                 go_o
);
  logic [3:0][7:0]         hdr_d, hdr_q;
  logic [MAX_LEN-1:0][7:0] pay_d, pay_q;
  logic [IDX_W-1:0]        cnt_d;
  logic                    load;

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_pay
    assign pay_d[g] = payload_i[g*8 +: 8];
  end

  aux_req_hdr #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .CNT_W(IDX_W)) u_hdr (
    .i2c_i (i2c_i),
    .cmd_i (cmd_i),
    .addr_i(addr_i),
    .len_i (len_i),
    .hdr_o (hdr_d),
    .cnt_o (cnt_d)
  );

  aux_req_seq #(.IDX_W(IDX_W), .DLY_W(DLY_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go_i),
    .done_st_i(done_st_i),
    .cnt_i    (cnt_d),
    .dly_i    (delay_i),
    .load_o   (load),
    .busy_o   (busy_o),
    .we_o     (buf_we_o),
    .idx_o    (buf_idx_o),
    .cnt_o    (wr_cnt_o),
    .dly_o    (delay_o),
    .ack_o    (done_ack_o),
    .go_o     (go_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_q <= '0;
      pay_q <= '0;
    end else if (load) begin
      hdr_q <= hdr_d;
      pay_q <= pay_d;
    end
  end

  aux_req_bytesel #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W)) u_sel (
    .idx_i (buf_idx_o),
    .hdr_i (hdr_q),
    .pay_i (pay_q),
    .data_o(buf_data_o)
  );

  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> wr_cnt_o >= IDX_W'(3) && wr_cnt_o <= IDX_W'(MAX_LEN + 4));
  assert_idx_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> buf_idx_o < wr_cnt_o);
  assert_no_we_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !buf_we_o && !done_ack_o && !go_o);
endmodule

// File: tb/tb_aux_req_composer.sv
module tb_aux_req_composer;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         go_i = 1'b0;
  logic         i2c_i = 1'b0;
  logic [3:0]   cmd_i = '0;
  logic [19:0]  addr_i = '0;
  logic [4:0]   len_i = '0;
  logic [127:0] payload_i = '0;
  logic [3:0]   delay_i = '0;
  logic         done_st_i = 1'b0;
  logic         busy_o, buf_we_o, done_ack_o, go_o;
  logic [4:0]   buf_idx_o, wr_cnt_o;
  logic [7:0]   buf_data_o;
  logic [3:0]   delay_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  aux_req_composer dut (
    .clk_i(clk), .rst_ni(rst_ni), .go_i(go_i), .i2c_i(i2c_i), .cmd_i(cmd_i),
    .addr_i(addr_i), .len_i(len_i), .payload_i(payload_i), .delay_i(delay_i),
    .done_st_i(done_st_i), .busy_o(busy_o), .buf_we_o(buf_we_o),
    .buf_idx_o(buf_idx_o), .buf_data_o(buf_data_o), .wr_cnt_o(wr_cnt_o),
    .delay_o(delay_o), .done_ack_o(done_ack_o), .go_o(go_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  // One request; rel_cyc: cycle at which done_st_i drops (0 = already low)
  task automatic do_req(input logic i2c, input logic [3:0] cmd, input logic [19:0] addr,
                        input int len, input logic [3:0] dly, input int rel_cyc,
                        input int extra_go);
    logic [7:0] exp_b [0:31];
    logic       wr;
    int n, nw, ack_cyc, go_cyc, last_busy, exp_go;
    wr = i2c ? (cmd == 4'b0000 || cmd == 4'b0100) : (cmd == 4'b1000);
    n = (len != 0 ? 4 : 3) + (wr ? len : 0);
    i2c_i = i2c; cmd_i = cmd; addr_i = addr; len_i = 5'(len); delay_i = dly;
    for (int k = 0; k < 16; k++) payload_i[k*8 +: 8] = 8'(k * 17 + 3) ^ addr[7:0];
    exp_b[0] = {cmd, addr[19:16]};
    exp_b[1] = addr[15:8];
    exp_b[2] = addr[7:0];
    exp_b[3] = 8'(len - 1);
    for (int k = 0; k < 16; k++) exp_b[4 + k] = 8'(k * 17 + 3) ^ addr[7:0];
    done_st_i = (rel_cyc > 0);
    go_i = 1'b1;
    nw = 0; ack_cyc = -1; go_cyc = -1; last_busy = -1;
    for (int cyc = 1; cyc <= 60; cyc++) begin
      @(negedge clk);
      go_i = 1'b0;
      if (cyc == 1) begin
        chk("R4", "byte count", int'(wr_cnt_o), n);
        chk("R10", "delay", int'(delay_o), int'(dly));
      end
      if (buf_we_o) begin
        chk("R6", "write index", int'(buf_idx_o), nw);
        chk("R6", "write cycle", cyc, nw + 1);
        if (nw < 32) begin
          if (nw == 0)      chk("R1", "byte0", int'(buf_data_o), int'(exp_b[0]));
          else if (nw < 3)  chk("R2", "addr byte", int'(buf_data_o), int'(exp_b[nw]));
          else if (nw == 3) chk("R3", "length byte", int'(buf_data_o), int'(exp_b[3]));
          else              chk("R6", "payload byte", int'(buf_data_o), int'(exp_b[nw]));
        end
        nw++;
      end
      if (done_ack_o) ack_cyc = cyc;
      if (go_o) go_cyc = cyc;
      if (busy_o) last_busy = cyc;
      if (cyc == rel_cyc) done_st_i = 1'b0;
      if (cyc == extra_go) begin
        go_i = 1'b1;
        addr_i = ~addr;
        cmd_i = ~cmd;
        len_i = 5'd16;
        delay_i = ~dly;
      end
    end
    exp_go = (rel_cyc + 1 > n + 3) ? rel_cyc + 1 : n + 3;
    chk("R5", "writes issued", nw, n);
    chk("R7", "ack cycle", ack_cyc, n + 1);
    chk("R7", "go cycle", go_cyc, exp_go);
    chk("R8", "last busy cycle", last_busy, exp_go);
    done_st_i = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R9", "busy in reset", int'(busy_o), 0);
    chk("R9", "we in reset", int'(buf_we_o), 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R9", "busy after reset", int'(busy_o), 0);
    chk("R9", "go after reset", int'(go_o), 0);
    chk("R9", "ack after reset", int'(done_ack_o), 0);
    chk("R9", "count after reset", int'(wr_cnt_o), 0);
  endtask

  task automatic t_native_read;   do_req(1'b0, 4'b1001, 20'hABCDE, 16, 4'h5, 0, 0); endtask
  task automatic t_native_write;  do_req(1'b0, 4'b1000, 20'h12345, 16, 4'hA, 0, 0); endtask
  task automatic t_i2c_mot_addr;  do_req(1'b1, 4'b0100, 20'h00050, 0, 4'h1, 0, 0); endtask
  task automatic t_i2c_write1;    do_req(1'b1, 4'b0000, 20'hF0F0F, 1, 4'h7, 0, 0); endtask
  task automatic t_i2c_read;      do_req(1'b1, 4'b0001, 20'h80001, 5, 4'h3, 0, 0); endtask
  task automatic t_i2c_nonwrite;  do_req(1'b1, 4'b1000, 20'h3C3C3, 7, 4'h2, 0, 0); endtask
  task automatic t_native_zero;   do_req(1'b0, 4'b1000, 20'h55AA5, 0, 4'hF, 0, 0); endtask
  task automatic t_done_held;     do_req(1'b0, 4'b1000, 20'h0F00F, 3, 4'h9, 30, 0); endtask
  task automatic t_ignore_go;     do_req(1'b0, 4'b1000, 20'h76543, 8, 4'h6, 0, 5); endtask

  initial begin
    t_reset();
    t_native_read();
    t_native_write();
    t_i2c_mot_addr();
    t_i2c_write1();
    t_i2c_read();
    t_i2c_nonwrite();
    t_native_zero();
    t_done_held();
    t_ignore_go();
    summary();
  end
endmodule